// File: doc/BRIEF.md
# Predicated Instruction Condition Unit

This block is a tiny execute stage in which every instruction is predicated. It receives one 32-bit instruction word per clock. It decodes a four-bit condition field from that word and tests it against a status register holding four flags: negative (N), zero (Z), carry (C) and overflow (V). It then either carries out the operation or drops the instruction as a no-op. The supported operations are a compare, an exclusive-or test, and an add into a four-entry register file. The compare subtracts and sets all four flags. The test sets N and Z.

There is no handshake at the edge of the block. A new instruction is presented every cycle, and its effect on the flags and the register file becomes visible after the next rising clock edge. A combinational pass indication reports whether the current instruction's condition is met. A read port lets the surrounding logic inspect any register.

Because every instruction is conditional, short sequences can evaluate compound conditions without branching. For example, an unconditional test against one constant, a test against a second constant predicated on "not equal", and an increment predicated on "equal" together count the inputs that match either constant.

Top module: `pred_exec_unit`

## Requirements
- R1: The instruction word is decoded as follows. Bits 31:28 hold the condition code. Bits 27:26 hold the operation: 00 compare, 01 test, 10 add, 11 no operation. Bits 25:24 give the source register rs, and bits 23:22 give the destination register rd. Bit 16 set selects register operand rt (bits 1:0); bit 16 clear selects immediate bits 15:0, zero-extended. Bits 21:17 are ignored.
- R2: Condition 1110 always passes, and condition 1111 never passes.
- R3: Condition 0000 passes only when Z is 1, and condition 0001 passes only when Z is 0.
- R4: Condition 1011 (signed less-than) passes when N differs from V, and condition 1010 passes when N equals V.
- R5: The remaining conditions decode as follows: 0010 passes on C, 0011 on not C, 0100 on N, 0101 on not N, 0110 on V, 0111 on not V, 1000 on C and not Z, 1001 on not C or Z, 1100 on not Z and N equal to V, 1101 on Z or N not equal to V.
- R6: A passing compare forms rs minus the operand. It sets N to the result's MSB, Z when the result is zero, C when no borrow occurs, and V on signed overflow. flags_o is ordered {N,Z,C,V}.
- R7: A passing test forms rs XOR the operand. It sets N to the result's MSB and Z when the result is zero, and leaves C and V unchanged. A test followed by a not-equal test followed by an equal-predicated increment counts the values that match either constant.
- R8: A passing add writes rs plus the operand (modulo 2^32) into rd and leaves the flags unchanged.
- R9: An instruction whose condition fails changes neither the register file nor the flags. A no-operation code changes neither even when its condition passes.
- R10: A synchronous active-high reset clears the flags and all registers to zero.
- R11: fire_o reports, in the same cycle and combinationally, whether the current instruction's condition passes against the current flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word presented this cycle |
| rd_sel_i | input | 2 | Register index for the inspection read port |
| fire_o | output | 1 | Condition of the current instruction passes |
| flags_o | output | 4 | Status flags {N,Z,C,V} |
| rd_data_o | output | 32 | Contents of the register selected by rd_sel_i |

## Verification
A corrupted flag bit shows up on fire_o in the very cycle the next instruction that depends on that flag is presented, and on flags_o directly one edge after it was written. A wrong register value can be seen through the read port one edge after the bad write. It also spreads into later flags whenever that register feeds a compare or a test. A reference model that is compared after every edge therefore localises a fault to the single instruction that caused it.

// File: rtl/pred_pkg.sv
`timescale 1ns/1ps
package pred_pkg;
    localparam int RIDX_W = 2;
    localparam int NREGS  = 1 << RIDX_W;
    localparam int IMM_W  = 16;

    typedef enum logic [3:0] {
        C_EQ = 4'h0, C_NE = 4'h1, C_CS = 4'h2, C_CC = 4'h3,
        C_MI = 4'h4, C_PL = 4'h5, C_VS = 4'h6, C_VC = 4'h7,
        C_HI = 4'h8, C_LS = 4'h9, C_GE = 4'hA, C_LT = 4'hB,
        C_GT = 4'hC, C_LE = 4'hD, C_AL = 4'hE, C_NV = 4'hF
    } cond_e;

    typedef enum logic [1:0] {
        OP_CMP = 2'd0, OP_TEQ = 2'd1, OP_ADD = 2'd2, OP_NOP = 2'd3
    } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        cond_e             cond;
        op_e               op;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        rsvd;
        logic              use_reg;
        logic [IMM_W-1:0]  imm;
    } dec_t;

    function automatic dec_t decode(input logic [31:0] w);
        dec_t d;
        d.cond    = cond_e'(w[31:28]);
        d.op      = op_e'(w[27:26]);
        d.rs      = w[25:24];
        d.rd      = w[23:22];
        d.rsvd    = w[21:17];
        d.use_reg = w[16];
        d.imm     = w[15:0];
        return d;
    endfunction

    function automatic logic cond_pass(input cond_e c, input flags_t f);
        logic nv_eq;
        nv_eq = (f.n == f.v);
        case (c)
            C_EQ: return f.z;
            C_NE: return !f.z;
            C_CS: return f.c;
            C_CC: return !f.c;
            C_MI: return f.n;
            C_PL: return !f.n;
            C_VS: return f.v;
            C_VC: return !f.v;
            C_HI: return f.c && !f.z;
            C_LS: return !f.c || f.z;
            C_GE: return nv_eq;
            C_LT: return !nv_eq;
            C_GT: return !f.z && nv_eq;
            C_LE: return f.z || !nv_eq;
            C_AL: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/pred_cond_eval.sv
`timescale 1ns/1ps
module pred_cond_eval
    import pred_pkg::*;
(
    input  cond_e  cond,
    input  flags_t flags,
    output logic   pass
);
    always_comb pass = cond_pass(cond, flags);
endmodule

// File: rtl/pred_alu.sv
`timescale 1ns/1ps
module pred_alu
    import pred_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  flags_t            flags_in,
    output logic [DATA_W-1:0] result,
    output flags_t            flags_out,
    output logic              wr_reg,
    output logic              wr_flags
);
    logic [DATA_W:0]   diff;
    logic [DATA_W-1:0] xr;

    always_comb begin
        diff      = {1'b0, a} - {1'b0, b};
        xr        = a ^ b;
        result    = a + b;
        flags_out = flags_in;
        wr_reg    = 1'b0;
        wr_flags  = 1'b0;
        case (op)
            OP_CMP: begin
                wr_flags    = 1'b1;
                flags_out.n = diff[DATA_W-1];
                flags_out.z = (diff[DATA_W-1:0] == '0);
                flags_out.c = !diff[DATA_W];
                flags_out.v = (a[DATA_W-1] != b[DATA_W-1]) &&
                              (diff[DATA_W-1] != a[DATA_W-1]);
            end
            OP_TEQ: begin
                wr_flags    = 1'b1;
                flags_out.n = xr[DATA_W-1];
                flags_out.z = (xr == '0);
            end
            OP_ADD:  wr_reg = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pred_regfile.sv
`timescale 1ns/1ps
module pred_regfile
    import pred_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RIDX_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    input  logic [RIDX_W-1:0] ra,
    input  logic [RIDX_W-1:0] rb,
    input  logic [RIDX_W-1:0] rc,
    output logic [DATA_W-1:0] qa,
    output logic [DATA_W-1:0] qb,
    output logic [DATA_W-1:0] qc
);
    logic [DATA_W-1:0] regs [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (we && wa == RIDX_W'(i))
                regs[i] <= wd;
        end
    end

    assign qa = regs[ra];
    assign qb = regs[rb];
    assign qc = regs[rc];
endmodule

// File: rtl/pred_exec_unit.sv
`timescale 1ns/1ps
module pred_exec_unit
    import pred_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       instr_i,
    input  logic [1:0]        rd_sel_i,
    output logic              fire_o,
    output logic [3:0]        flags_o,
    output logic [DATA_W-1:0] rd_data_o
);
    dec_t              dec;
    flags_t            flags_q;
    flags_t            flags_nx;
    logic              pass;
    logic [DATA_W-1:0] src_a;
    logic [DATA_W-1:0] src_rt;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] alu_res;
    logic              alu_wr_reg;
    logic              alu_wr_flags;
    logic              reg_we;
    logic              flag_we;
    logic              unused_rsvd;

    assign dec         = decode(instr_i);
    assign unused_rsvd = ^dec.rsvd;
    assign operand     = dec.use_reg ? src_rt : DATA_W'(dec.imm);

    pred_cond_eval u_cond (
        .cond (dec.cond),
        .flags(flags_q),
        .pass (pass)
    );

    pred_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (dec.op),
        .a        (src_a),
        .b        (operand),
        .flags_in (flags_q),
        .result   (alu_res),
        .flags_out(flags_nx),
        .wr_reg   (alu_wr_reg),
        .wr_flags (alu_wr_flags)
    );

    assign reg_we  = pass && alu_wr_reg;
    assign flag_we = pass && alu_wr_flags;

    pred_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk(clk),
        .rst(rst),
        .we (reg_we),
        .wa (dec.rd),
        .wd (alu_res),
        .ra (dec.rs),
        .rb (dec.imm[RIDX_W-1:0]),
        .rc (rd_sel_i),
        .qa (src_a),
        .qb (src_rt),
        .qc (rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (flag_we)
            flags_q <= flags_nx;
    end

    assign fire_o  = pass;
    assign flags_o = flags_q;
endmodule

// File: rtl/pred_exec_chk.sv
`timescale 1ns/1ps
module pred_exec_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] instr_i,
    input logic        fire_o,
    input logic [3:0]  flags_o,
    input logic        reg_we
);
    assert_always_R2: assert property (@(posedge clk) disable iff (rst)
        instr_i[31:28] == 4'hE |-> fire_o);

    assert_never_R2: assert property (@(posedge clk) disable iff (rst)
        instr_i[31:28] == 4'hF |-> !fire_o);

    assert_eq_tracks_z_R3: assert property (@(posedge clk) disable iff (rst)
        instr_i[31:28] == 4'h0 |-> fire_o == flags_o[2]);

    assert_lt_from_nv_R4: assert property (@(posedge clk) disable iff (rst)
        instr_i[31:28] == 4'hB |-> fire_o == (flags_o[3] != flags_o[0]));

    assert_add_keeps_flags_R8: assert property (@(posedge clk) disable iff (rst)
        instr_i[27:26] == 2'b10 |=> $stable(flags_o));

    assert_fail_keeps_flags_R9: assert property (@(posedge clk) disable iff (rst)
        !fire_o |=> $stable(flags_o));

    assert_fail_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        !fire_o |-> !reg_we);

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> flags_o == 4'h0);
endmodule

bind pred_exec_unit pred_exec_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .instr_i(instr_i),
    .fire_o (fire_o),
    .flags_o(flags_o),
    .reg_we (reg_we)
);

// File: tb/tb_pred_exec_unit.sv
`timescale 1ns/1ps
module tb_pred_exec_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr_i = 32'hF000_0000;
    logic [1:0]  rd_sel_i = 2'd0;
    logic        fire_o;
    logic [3:0]  flags_o;
    logic [31:0] rd_data_o;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mreg [4];
    logic [3:0]  mflg;

    always #2 clk = ~clk;

    pred_exec_unit dut (
        .clk(clk), .rst(rst), .instr_i(instr_i), .rd_sel_i(rd_sel_i),
        .fire_o(fire_o), .flags_o(flags_o), .rd_data_o(rd_data_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int c, input int op, input int rs,
                                       input int rd, input int ur, input int imm);
        return {c[3:0], op[1:0], rs[1:0], rd[1:0], 5'd0, ur[0], imm[15:0]};
    endfunction

    // Reference condition evaluation, flags as {N,Z,C,V}
    function automatic logic mpass(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'h0: return z;             4'h1: return !z;
            4'h2: return cy;            4'h3: return !cy;
            4'h4: return n;             4'h5: return !n;
            4'h6: return v;             4'h7: return !v;
            4'h8: return cy && !z;      4'h9: return !cy || z;
            4'hA: return n == v;        4'hB: return n != v;
            4'hC: return !z && n == v;  4'hD: return z || n != v;
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string ctag(input logic [3:0] c);
        if (c == 4'h0 || c == 4'h1) return "R11/R1/R3";
        if (c == 4'hA || c == 4'hB) return "R11/R1/R4";
        if (c == 4'hE || c == 4'hF) return "R11/R1/R2";
        return "R11/R1/R5";
    endfunction

    task automatic check_state(input string tag);
        chk({tag, " flags"}, {28'd0, flags_o}, {28'd0, mflg});
        for (int k = 0; k < 4; k++) begin
            rd_sel_i = k[1:0];
            #0.1;
            chk($sformatf("%s reg%0d", tag, k), rd_data_o, mreg[k]);
        end
    endtask

    task automatic run(input logic [31:0] w);
        logic        p;
        logic [31:0] a, b, r;
        logic [32:0] d;
        string       tag;
        @(negedge clk);
        instr_i = w;
        #0.5;
        p = mpass(w[31:28], mflg);
        chk(ctag(w[31:28]), {31'd0, fire_o}, {31'd0, p});
        a = mreg[w[25:24]];
        b = w[16] ? mreg[w[1:0]] : {16'd0, w[15:0]};
        @(posedge clk);
        tag = "R9";
        if (p) begin
            case (w[27:26])
                2'b00: begin
                    d = {1'b0, a} - {1'b0, b};
                    mflg = {d[31], d[31:0] == 0, !d[32],
                            (a[31] != b[31]) && (d[31] != a[31])};
                    tag = "R6";
                end
                2'b01: begin
                    r = a ^ b;
                    mflg[3] = r[31];
                    mflg[2] = (r == 0);
                    tag = "R7";
                end
                2'b10: begin
                    mreg[w[23:22]] = a + b;
                    tag = "R8";
                end
                default: ;
            endcase
        end
        #0.5;
        check_state(tag);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int vals[6] = '{33, 63, 7, 0, 34, 62};
        int hits;
        for (int k = 0; k < 4; k++) mreg[k] = 32'd0;
        mflg = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        check_state("R10 reset");

        // compound OR test: r2 = r3(0) + x; TEQ r2,#33; TEQNE r2,#63; ADDEQ r1,r1,#1
        hits = 0;
        foreach (vals[i]) begin
            run(mk(14, 2, 3, 2, 0, vals[i]));
            run(mk(14, 1, 2, 0, 0, 33));
            run(mk(1, 1, 2, 0, 0, 63));
            run(mk(0, 2, 1, 1, 0, 1));
            if (vals[i] == 33 || vals[i] == 63) hits++;
            rd_sel_i = 2'd1;
            #0.1;
            chk("R7 or-count", rd_data_o, hits);
        end

        // directed flag corners: 0 - 1 gives N, borrow; equal gives Z and C
        run(mk(14, 0, 0, 0, 0, 1));
        run(mk(11, 2, 0, 3, 0, 5));
        run(mk(10, 2, 0, 3, 0, 9));
        run(mk(14, 0, 3, 0, 0, 5));
        run(mk(15, 2, 0, 0, 0, 77));
        run(mk(14, 3, 0, 0, 0, 0) | 32'h003E_0000);

        // build large operands for overflow cases, then a random stream
        for (int k = 0; k < 40; k++) run(mk(14, 2, 0, 0, 0, 16'hFFFF));
        for (int k = 0; k < 2500; k++) begin
            logic [31:0] w;
            w = $urandom;
            w[21:17] = 5'd0;
            if (w[27:26] == 2'b11 && w[5]) w[27:26] = 2'b00;
            run(w);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule